// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a two-port memory. One port only writes and the other only reads. Each port has its own clock, clock enable and address, so a write and a read can proceed in the same cycle. Both ports see one shared array of `TOTAL_BITS` bits, but each port can use a different data width. The port with the narrower width addresses sub-words of the wider word. Address n on a port with width W covers array bits `[n*W +: W]`, so low addresses fall on the least significant bits of a wide word.

The write port has per-lane write enables. The read data sits in an output register, which an asynchronous clear input forces to zero. Each port also has an address-hold input. While it is high, the port ignores its address bus and reuses the address it captured last.

Top module: `mw_sdp_ram`

## Requirements
- R1: A write and a read to different addresses on the same edge both take effect. The read returns the stored content and the write updates its target.
- R2: When `rd_clken` and `rd_en` are both high at an `rd_clk` edge, `rd_q` shows array bits `[a*RD_W +: RD_W]` after that edge, where a is the effective read address.
- R3: A write with all lanes enabled stores `wr_data` into array bits `[a*WR_W +: WR_W]`, where a is the effective write address. Bit 0 of the data lands on the lowest array bit.
- R4: Write lane k covers data bits `[8k+7:8k]` and is written only when `wr_be[k]` is 1. When WR_W is below 8, the single bit `wr_be[0]` gates the whole word. Lanes with their enable at 0 keep their old content.
- R5: On an enabled write edge with `wr_addr_hold` high, the write goes to the previously captured write address and the value on `wr_addr` is ignored.
- R6: On an enabled read edge with `rd_addr_hold` high, the read uses the previously captured read address and the value on `rd_addr` is ignored.
- R7: An edge with a port's clock enable low is ignored entirely. With `wr_clken` low nothing is written. With `rd_clken` low, `rd_q` and the captured read address both stay unchanged.
- R8: When `rd_en` is low, `rd_q` holds its value.
- R9: While `q_clr` is high, `rd_q` is zero. The clear acts at once, without waiting for a clock edge.
- R10: When the two ports share a clock and access the same location on the same edge, the read returns the data stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_clken | input | 1 | Write port clock enable |
| wr_en | input | 1 | Write request |
| wr_addr | input | WAW | Write address in WR_W-bit units |
| wr_data | input | WR_W | Write data |
| wr_be | input | BE_W | Per-lane write enables |
| wr_addr_hold | input | 1 | Keep the previously captured write address |
| rd_clk | input | 1 | Read port clock |
| rd_clken | input | 1 | Read port clock enable |
| rd_en | input | 1 | Read request |
| rd_addr | input | RAW | Read address in RD_W-bit units |
| rd_addr_hold | input | 1 | Keep the previously captured read address |
| q_clr | input | 1 | Asynchronous clear of the read register |
| rd_q | output | RD_W | Registered read data |

## Verification
The bench builds the block with a 512-bit array, a 32-bit write port and an 8-bit read port, and drives both ports from one clock. With these values the write port has four byte lanes, so partial-lane writes can be tested. Each wide word maps to four read addresses, which exposes the sub-word ordering. The shared clock makes same-edge collisions, both same-address and different-address, possible. A bit-addressed reference model predicts every read, including reads under address hold and reads after gated edges.

// File: rtl/mwsdp_pkg.sv
`timescale 1ns/1ps
package mwsdp_pkg;
  localparam int LANE_BITS = 8;

  function automatic int lane_w(input int w);
    return (w < LANE_BITS) ? w : LANE_BITS;
  endfunction

  function automatic int lane_n(input int w);
    return w / lane_w(w);
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/mwsdp_addr_hold.sv
`timescale 1ns/1ps
module mwsdp_addr_hold #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          clken,
  input  logic          hold,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff,
  output logic [AW-1:0] addr_q
);
  assign addr_eff = hold ? addr_q : addr_in;

  always_ff @(posedge clk) begin
    if (clken) addr_q <= addr_eff;
  end
endmodule

// File: rtl/mwsdp_map.sv
`timescale 1ns/1ps
module mwsdp_map #(
  parameter int AW  = 8,
  parameter int IW  = 8,
  parameter int OFW = 5,
  parameter int SH  = 0,
  parameter int PW  = 8
) (
  input  logic [AW-1:0]  addr,
  output logic [IW-1:0]  idx,
  output logic [OFW-1:0] off
);
  localparam int SUB_MASK = (1 << SH) - 1;

  logic [AW-1:0] sub;

  assign idx = IW'(addr >> SH);
  assign sub = addr & AW'(SUB_MASK);
  assign off = OFW'(sub) * OFW'(PW);
endmodule

// File: rtl/mwsdp_array.sv
`timescale 1ns/1ps
module mwsdp_array #(
  parameter int WIDE_W = 32,
  parameter int DEPTH  = 256,
  parameter int IW     = 8,
  parameter int OFW    = 5,
  parameter int WR_W   = 32,
  parameter int LW     = 8,
  parameter int LN     = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [IW-1:0]     w_idx,
  input  logic [OFW-1:0]    w_off,
  input  logic [WR_W-1:0]   w_data,
  input  logic [LN-1:0]     w_lane,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [IW-1:0]     r_idx,
  input  logic              q_clr,
  output logic [WIDE_W-1:0] word_q
);
  logic [WIDE_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      for (int l = 0; l < LN; l++) begin
        if (w_lane[l]) mem[w_idx][w_off + OFW'(l * LW) +: LW] <= w_data[l*LW +: LW];
      end
    end
  end

  always_ff @(posedge rd_clk or posedge q_clr) begin
    if (q_clr)   word_q <= '0;
    else if (re) word_q <= mem[r_idx];
  end
endmodule

// File: rtl/mwsdp_rd_sel.sv
`timescale 1ns/1ps
module mwsdp_rd_sel #(
  parameter int WIDE_W = 32,
  parameter int RD_W   = 8,
  parameter int OFW    = 5
) (
  input  logic              clk,
  input  logic              q_clr,
  input  logic              re,
  input  logic [OFW-1:0]    off_in,
  input  logic [WIDE_W-1:0] word,
  output logic [RD_W-1:0]   q
);
  logic [OFW-1:0] off_q;

  always_ff @(posedge clk or posedge q_clr) begin
    if (q_clr)   off_q <= '0;
    else if (re) off_q <= off_in;
  end

  assign q = word[off_q +: RD_W];
endmodule

// File: rtl/mw_sdp_ram.sv
`timescale 1ns/1ps
module mw_sdp_ram
  import mwsdp_pkg::*;
#(
  parameter int  TOTAL_BITS = 8192,
  parameter int  WR_W       = 32,
  parameter int  RD_W       = 8,
  localparam int WAW        = $clog2(TOTAL_BITS / WR_W),
  localparam int RAW        = $clog2(TOTAL_BITS / RD_W),
  localparam int BE_W       = lane_n(WR_W)
) (
  input  logic            wr_clk,
  input  logic            wr_clken,
  input  logic            wr_en,
  input  logic [WAW-1:0]  wr_addr,
  input  logic [WR_W-1:0] wr_data,
  input  logic [BE_W-1:0] wr_be,
  input  logic            wr_addr_hold,
  input  logic            rd_clk,
  input  logic            rd_clken,
  input  logic            rd_en,
  input  logic [RAW-1:0]  rd_addr,
  input  logic            rd_addr_hold,
  input  logic            q_clr,
  output logic [RD_W-1:0] rd_q
);
  localparam int WIDE_W = (WR_W > RD_W) ? WR_W : RD_W;
  localparam int DEPTH  = TOTAL_BITS / WIDE_W;
  localparam int IW     = $clog2(DEPTH);
  localparam int OFW    = $clog2(WIDE_W);
  localparam int WSH    = $clog2(WIDE_W / WR_W);
  localparam int RSH    = $clog2(WIDE_W / RD_W);
  localparam int LW     = lane_w(WR_W);

  if (!(is_pow2(WR_W) && is_pow2(RD_W) && is_pow2(TOTAL_BITS) &&
        WIDE_W >= 2 && DEPTH >= 2)) begin : g_bad_geometry
    $error("mw_sdp_ram: widths and capacity must be powers of two with depth of at least two");
  end

  logic [WAW-1:0] wr_addr_eff, wr_addr_q;
  logic [RAW-1:0] rd_addr_eff, rd_addr_q;
  logic [IW-1:0]  w_idx, r_idx;
  logic [OFW-1:0] w_off, r_off;
  logic [WIDE_W-1:0] word_q;
  logic we, re;

  assign we = wr_clken & wr_en;
  assign re = rd_clken & rd_en;

  mwsdp_addr_hold #(.AW(WAW)) u_wr_hold (
    .clk(wr_clk), .clken(wr_clken), .hold(wr_addr_hold),
    .addr_in(wr_addr), .addr_eff(wr_addr_eff), .addr_q(wr_addr_q)
  );

  mwsdp_addr_hold #(.AW(RAW)) u_rd_hold (
    .clk(rd_clk), .clken(rd_clken), .hold(rd_addr_hold),
    .addr_in(rd_addr), .addr_eff(rd_addr_eff), .addr_q(rd_addr_q)
  );

  mwsdp_map #(.AW(WAW), .IW(IW), .OFW(OFW), .SH(WSH), .PW(WR_W)) u_wr_map (
    .addr(wr_addr_eff), .idx(w_idx), .off(w_off)
  );

  mwsdp_map #(.AW(RAW), .IW(IW), .OFW(OFW), .SH(RSH), .PW(RD_W)) u_rd_map (
    .addr(rd_addr_eff), .idx(r_idx), .off(r_off)
  );

  mwsdp_array #(
    .WIDE_W(WIDE_W), .DEPTH(DEPTH), .IW(IW), .OFW(OFW),
    .WR_W(WR_W), .LW(LW), .LN(BE_W)
  ) u_array (
    .wr_clk(wr_clk), .we(we), .w_idx(w_idx), .w_off(w_off),
    .w_data(wr_data), .w_lane(wr_be),
    .rd_clk(rd_clk), .re(re), .r_idx(r_idx), .q_clr(q_clr), .word_q(word_q)
  );

  mwsdp_rd_sel #(.WIDE_W(WIDE_W), .RD_W(RD_W), .OFW(OFW)) u_rd_sel (
    .clk(rd_clk), .q_clr(q_clr), .re(re), .off_in(r_off),
    .word(word_q), .q(rd_q)
  );
endmodule

// File: rtl/mwsdp_checks.sv
`timescale 1ns/1ps
module mwsdp_checks #(
  parameter int RD_W = 8,
  parameter int WAW  = 8,
  parameter int RAW  = 8
) (
  input logic            wr_clk,
  input logic            wr_clken,
  input logic            wr_addr_hold,
  input logic [WAW-1:0]  wr_addr_q,
  input logic            rd_clk,
  input logic            rd_clken,
  input logic            rd_en,
  input logic            rd_addr_hold,
  input logic [RAW-1:0]  rd_addr_q,
  input logic            q_clr,
  input logic [RD_W-1:0] rd_q
);
  // R9: the output is zero whenever the clear is active at a read edge
  assert_clear_zero_R9: assert property (@(posedge rd_clk)
    q_clr |-> (rd_q == '0));

  // R8 / R7: no enabled read request means the output keeps its value
  assert_idle_hold_R8: assert property (@(posedge rd_clk) disable iff (q_clr)
    !(rd_clken && rd_en) |=> $stable(rd_q));

  // R6: a held read address is not replaced
  assert_rd_addr_hold_R6: assert property (@(posedge rd_clk) disable iff (q_clr)
    (rd_clken && rd_addr_hold) |=> $stable(rd_addr_q));

  // R7: a gated read edge leaves the captured address alone
  assert_rd_gate_R7: assert property (@(posedge rd_clk) disable iff (q_clr)
    !rd_clken |=> $stable(rd_addr_q));

  // R5: a held write address is not replaced
  assert_wr_addr_hold_R5: assert property (@(posedge wr_clk) disable iff (q_clr)
    (wr_clken && wr_addr_hold) |=> $stable(wr_addr_q));
endmodule

bind mw_sdp_ram mwsdp_checks #(.RD_W(RD_W), .WAW(WAW), .RAW(RAW)) u_chk (
  .wr_clk(wr_clk), .wr_clken(wr_clken), .wr_addr_hold(wr_addr_hold),
  .wr_addr_q(wr_addr_q), .rd_clk(rd_clk), .rd_clken(rd_clken),
  .rd_en(rd_en), .rd_addr_hold(rd_addr_hold), .rd_addr_q(rd_addr_q),
  .q_clr(q_clr), .rd_q(rd_q)
);

// File: tb/mw_sdp_ram_bench.sv
`timescale 1ns/1ps
module mw_sdp_ram_bench;
  localparam int TB = 512;
  localparam int WW = 32;
  localparam int RW = 8;
  localparam int WA = $clog2(TB / WW);
  localparam int RA = $clog2(TB / RW);
  localparam int BW = WW / 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          wr_clken = 0, wr_en = 0, wr_addr_hold = 0;
  logic [WA-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [BW-1:0] wr_be = '0;
  logic          rd_clken = 0, rd_en = 0, rd_addr_hold = 0, q_clr = 1;
  logic [RA-1:0] rd_addr = '0;
  logic [RW-1:0] rd_q;

  mw_sdp_ram #(.TOTAL_BITS(TB), .WR_W(WW), .RD_W(RW)) u_mw_sdp_ram (
    .wr_clk(clk), .wr_clken(wr_clken), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_addr_hold(wr_addr_hold),
    .rd_clk(clk), .rd_clken(rd_clken), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_addr_hold(rd_addr_hold), .q_clr(q_clr), .rd_q(rd_q)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic          ref_bits [TB];
  logic [WA-1:0] wlat_m = '0;
  logic [RA-1:0] rlat_m = '0;
  logic [RW-1:0] exp_q [$];
  string         tag_q [$];
  bit            rd_fired = 0;
  logic [RW-1:0] last_q = '0;

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_q=%h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wce, input bit we, input logic [WA-1:0] wa,
                     input logic [WW-1:0] wd, input logic [BW-1:0] be, input bit wh,
                     input bit rce, input bit re, input logic [RA-1:0] ra,
                     input bit rh, input string tag);
    logic [WA-1:0] wa_e;
    logic [RA-1:0] ra_e;
    logic [RW-1:0] e;
    @(negedge clk);
    wr_clken = wce; wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be; wr_addr_hold = wh;
    rd_clken = rce; rd_en = re; rd_addr = ra; rd_addr_hold = rh;
    wa_e = wh ? wlat_m : wa;
    ra_e = rh ? rlat_m : ra;
    if (rce && re) begin
      for (int i = 0; i < RW; i++) e[i] = ref_bits[int'(ra_e) * RW + i];
      exp_q.push_back(e);
      tag_q.push_back(tag);
      last_q = e;
    end
    if (rce) rlat_m = ra_e;
    if (wce) wlat_m = wa_e;
    if (wce && we)
      for (int b = 0; b < BW; b++)
        if (be[b])
          for (int i = 0; i < 8; i++) ref_bits[int'(wa_e) * WW + b * 8 + i] = wd[b * 8 + i];
    @(posedge clk);
    rd_fired = rce && re;
    #1;
    wr_clken = 0;
    rd_clken = 0;
  endtask

  task automatic rd(input int a, input string tag);
    cyc(0, 0, '0, '0, '0, 0, 1, 1, RA'(a), 0, tag);
  endtask

  task automatic wr(input int a, input logic [WW-1:0] d, input logic [BW-1:0] be, input string tag);
    cyc(1, 1, WA'(a), d, be, 0, 0, 0, '0, 0, tag);
  endtask

  task automatic check_hold(input string tag);
    @(negedge clk);
    #1;
    check(tag, rd_q, last_q);
  endtask

  // monitor: compares each completed read against the scoreboard
  always @(negedge clk) begin
    if (rd_fired) begin
      rd_fired = 0;
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: rd_q=%h expected none", rd_q);
      end else begin
        check(tag_q.pop_front(), rd_q, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: rd_q=%h expected completion", rd_q);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R9 reset", rd_q, '0);
    q_clr = 0;

    for (int w = 0; w < TB / WW; w++) wr(w, 32'hA5C3_1E00 ^ (w * 32'h0107_0B0D), '1, "R3");
    for (int a = 0; a < TB / RW; a++) rd(a, "R2 R3 byte map");

    // R1: write one word while reading another
    cyc(1, 1, 2, 32'h1234_5678, '1, 0, 1, 1, 40, 0, "R1 concurrent read");
    for (int a = 8; a < 12; a++) rd(a, "R1 concurrent write");

    // R4: partial lanes, then no lanes
    wr(3, 32'hDEAD_BEEF, 4'b0101, "R4");
    for (int a = 12; a < 16; a++) rd(a, "R4 lanes");
    wr(4, 32'hFFFF_FFFF, 4'b0000, "R4");
    for (int a = 16; a < 20; a++) rd(a, "R4 no lanes");

    // R10: same location same edge returns old data
    cyc(1, 1, 5, 32'hCAFE_F00D, '1, 0, 1, 1, 21, 0, "R10 old data");
    rd(21, "R10 new data");

    // R5: write address hold
    wr(7, 32'h7777_7777, '1, "R5");
    cyc(1, 1, 2, 32'h0BAD_CAFE, '1, 1, 0, 0, '0, 0, "R5");
    for (int a = 28; a < 32; a++) rd(a, "R5 held target");
    for (int a = 8; a < 12; a++) rd(a, "R5 ignored addr");

    // R6: read address hold
    rd(10, "R6");
    cyc(0, 0, '0, '0, '0, 0, 1, 1, 40, 1, "R6 held read");

    // R7: gated edges
    rd(9, "R7");
    cyc(0, 0, '0, '0, '0, 0, 0, 1, 50, 0, "R7");
    check_hold("R7 gated read");
    cyc(0, 0, '0, '0, '0, 0, 1, 1, 33, 1, "R7 latch kept");
    cyc(0, 1, 0, 32'h0F0F_0F0F, '1, 0, 0, 0, '0, 0, "R7");
    for (int a = 0; a < 4; a++) rd(a, "R7 gated write");

    // R8: read enable low
    rd(6, "R8");
    cyc(0, 0, '0, '0, '0, 0, 1, 0, 7, 0, "R8");
    check_hold("R8 no read");

    // R9: asynchronous clear mid-cycle
    rd(13, "R9");
    @(negedge clk);
    #2 q_clr = 1;
    #1 check("R9 async clear", rd_q, '0);
    #1 q_clr = 0;
    last_q = '0;
    check_hold("R9 stays clear");
    rd(13, "R9 after clear");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule